// File: doc/BRIEF.md
# Serial On-Screen-Display Command Receiver

This block sits between a host controller and the on-screen-display engine of a video chip. The host sends 8-bit words over a three-wire link: an active-low select, a shift clock and a data line. The block samples the three wires in its own clock domain. It assembles words most significant bit first and decodes each word as either a command byte or a data byte.

A command byte selects one of six targets and may carry a payload:
- the write pointer,
- character writes,
- vertical placement and size,
- horizontal placement and size,
- display control,
- sync control.

Data bytes that follow go to the target last selected. Once character writing is selected, the block stays in that mode until select is released. In that mode every word is a character. It is written to the display memory at the current pointer, and the pointer then advances in raster order with wrap-around.

The outputs are the decoded control fields and a one-cycle write port for a character memory of 10 lines by 24 columns. A command bit in the display-control byte starts a soft reset. The soft reset clears every field and the pointer, and it lasts until select is released.

Top module: `osd_serial_cmd`

## Requirements
- R1: While ser_cs_n is low, a word is assembled from 8 rising edges of ser_clk, most significant bit first. A partial word is discarded when ser_cs_n goes high.
- R2: A word with bit 7 = 1 is a command byte, and its bits 6..4 select the target: 000 pointer, 001 character write, 010 vertical, 011 horizontal, 100 display control, 101 sync control. Codes 110 and 111 are ignored, and the previous target stays selected.
- R3: A word with bit 7 = 0 is a data byte. It goes to the target last selected. Several data bytes in a row all go to the same target.
- R4: The pointer command sets the line from bits 3..0 of the command byte. A following data byte sets the column from its bits 4..0. A line above 9 or a column above 23 leaves the pointer unchanged.
- R5: Once character write is selected, every word is character data, even a word with bit 7 = 1. Bit 7 becomes mem_attr and bits 5..0 become mem_code.
- R6: Each character gives one single-cycle mem_we pulse at the pointer position before the advance. The column then increments. Column 23 wraps to 0 and the line advances. Line 9 wraps to 0.
- R7: A rising edge on ser_cs_n selects the pointer target again, which ends character-write mode.
- R8: The vertical command byte bits 3..0 load vsize. Its data byte bits 5..0 load vpos. The horizontal command byte bits 3..0 load hsize. Its data byte bits 5..0 load hpos.
- R9: The display-control command byte (bit 0 clear) loads bits 3..1 into disp_ctrl. Its data byte bits 5..0 load disp_flags. The sync-control command byte bits 3..0 load sync_ctrl. Its data byte bits 3..0 load sync_detect.
- R10: A display-control command byte with bit 0 set does the following: it clears all fields and the pointer, sets soft_rst_o, and makes all words ignored until ser_cs_n rises. At that rising edge soft_rst_o clears.
- R11: rst_n low sets every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| mem_we | output | 1 | Character memory write strobe |
| mem_line | output | 4 | Write line, 0..9 |
| mem_col | output | 5 | Write column, 0..23 |
| mem_code | output | 6 | Character code |
| mem_attr | output | 1 | Character attribute |
| vsize | output | 4 | Vertical size field |
| vpos | output | 6 | Vertical start position |
| hsize | output | 4 | Horizontal size field |
| hpos | output | 6 | Horizontal start position |
| disp_ctrl | output | 3 | Display-control command bits |
| disp_flags | output | 6 | Display-control data bits, bit 0 = display on |
| sync_ctrl | output | 4 | Sync-control command bits |
| sync_detect | output | 4 | Sync detection setting |
| soft_rst_o | output | 1 | Soft reset in progress |

## Verification
Data bytes are sent in runs to each target. A repeated data byte to the vertical target shows whether the selection persists, and an invalid code between bytes shows whether it is rejected. Character runs are placed so that they cross the column limit and the last line, which separates a correct raster wrap from an off-by-one. A run also includes a character with bit 7 set, which separates locked decoding from command decoding. A partial word before select release tells whether the bit counter is cleared. An out-of-range pointer value, a data byte after select is released, and words sent during a soft reset each show up in the address of the next memory write.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_ADDR = 3'd0,
    CMD_CHAR = 3'd1,
    CMD_VERT = 3'd2,
    CMD_HORZ = 3'd3,
    CMD_DISP = 3'd4,
    CMD_SYNC = 3'd5
  } osd_cmd_e;

  typedef struct packed {
    logic vsz;
    logic vps;
    logic hsz;
    logic hps;
    logic dctl;
    logic dflg;
    logic sctl;
    logic sdet;
  } osd_reg_we_t;
endpackage

// File: rtl/osd_ser_rx.sv
module osd_ser_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_cs_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_q,
  output logic              cs_rise
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [SYNC_STAGES-1:0] cs_sync, ck_sync, dt_sync;
  logic                   cs_prev, ck_prev;
  logic [CNT_W-1:0]       cnt_q, cnt_n;
  logic [WORD_W-1:0]      sr_q, sr_n, word_n;
  logic                   vld_n;
  logic                   cs_s, ck_s, dt_s;

  assign cs_s    = cs_sync[SYNC_STAGES-1];
  assign ck_s    = ck_sync[SYNC_STAGES-1];
  assign dt_s    = dt_sync[SYNC_STAGES-1];
  assign cs_rise = cs_s & ~cs_prev;

  always_comb begin
    cnt_n  = cnt_q;
    sr_n   = sr_q;
    word_n = word_q;
    vld_n  = 1'b0;
    if (cs_s) begin
      cnt_n = '0;
    end else if (ck_s && !ck_prev) begin
      sr_n = {sr_q[WORD_W-2:0], dt_s};
      if (cnt_q == CNT_W'(WORD_W-1)) begin
        cnt_n  = '0;
        vld_n  = 1'b1;
        word_n = sr_n;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync  <= '1;
      ck_sync  <= '0;
      dt_sync  <= '0;
      cs_prev  <= 1'b1;
      ck_prev  <= 1'b0;
      cnt_q    <= '0;
      sr_q     <= '0;
      word_q   <= '0;
      word_vld <= 1'b0;
    end else begin
      cs_sync  <= {cs_sync[SYNC_STAGES-2:0], ser_cs_n};
      ck_sync  <= {ck_sync[SYNC_STAGES-2:0], ser_clk};
      dt_sync  <= {dt_sync[SYNC_STAGES-2:0], ser_dat};
      cs_prev  <= cs_s;
      ck_prev  <= ck_s;
      cnt_q    <= cnt_n;
      sr_q     <= sr_n;
      word_q   <= word_n;
      word_vld <= vld_n;
    end
  end
endmodule

// File: rtl/osd_cmd_decode.sv
module osd_cmd_decode
  import osd_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_vld,
  input  logic [7:0]  word_d,
  input  logic        cs_rise,
  output osd_reg_we_t reg_we,
  output logic        clr_all,
  output logic        set_line,
  output logic        set_col,
  output logic        char_wr,
  output logic        soft_rst
);
  osd_cmd_e cmd_q, cmd_n;
  logic     srst_n;
  logic     live;

  assign live     = word_vld & ~soft_rst;

  always_comb begin
    cmd_n    = cmd_q;
    srst_n   = soft_rst;
    reg_we   = '0;
    clr_all  = 1'b0;
    set_line = 1'b0;
    set_col  = 1'b0;
    char_wr  = 1'b0;
    if (live) begin
      if (cmd_q == CMD_CHAR) begin
        char_wr = 1'b1;
      end else if (word_d[7]) begin
        case (word_d[6:4])
          3'd0: begin cmd_n = CMD_ADDR; set_line = 1'b1; end
          3'd1: cmd_n = CMD_CHAR;
          3'd2: begin cmd_n = CMD_VERT; reg_we.vsz = 1'b1; end
          3'd3: begin cmd_n = CMD_HORZ; reg_we.hsz = 1'b1; end
          3'd4: begin
            cmd_n = CMD_DISP;
            if (word_d[0]) begin
              clr_all = 1'b1;
              srst_n  = 1'b1;
            end else begin
              reg_we.dctl = 1'b1;
            end
          end
          3'd5: begin cmd_n = CMD_SYNC; reg_we.sctl = 1'b1; end
          default: ;
        endcase
      end else begin
        case (cmd_q)
          CMD_ADDR: set_col     = 1'b1;
          CMD_VERT: reg_we.vps  = 1'b1;
          CMD_HORZ: reg_we.hps  = 1'b1;
          CMD_DISP: reg_we.dflg = 1'b1;
          CMD_SYNC: reg_we.sdet = 1'b1;
          default: ;
        endcase
      end
    end
    if (cs_rise) begin
      cmd_n  = CMD_ADDR;
      srst_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= CMD_ADDR;
      soft_rst <= 1'b0;
    end else begin
      cmd_q    <= cmd_n;
      soft_rst <= srst_n;
    end
  end
endmodule

// File: rtl/osd_reg_file.sv
module osd_reg_file
  import osd_cmd_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  osd_reg_we_t      reg_we,
  input  logic             clr_all,
  input  logic [7:0]       data,
  output logic [3:0]       vsize,
  output logic [POS_W-1:0] vpos,
  output logic [3:0]       hsize,
  output logic [POS_W-1:0] hpos,
  output logic [2:0]       disp_ctrl,
  output logic [5:0]       disp_flags,
  output logic [3:0]       sync_ctrl,
  output logic [3:0]       sync_detect
);
  logic [3:0]       vsize_n, hsize_n, sctl_n, sdet_n;
  logic [POS_W-1:0] vpos_n, hpos_n;
  logic [2:0]       dctl_n;
  logic [5:0]       dflg_n;

  always_comb begin
    vsize_n = vsize;
    vpos_n  = vpos;
    hsize_n = hsize;
    hpos_n  = hpos;
    dctl_n  = disp_ctrl;
    dflg_n  = disp_flags;
    sctl_n  = sync_ctrl;
    sdet_n  = sync_detect;
    if (clr_all) begin
      vsize_n = '0; vpos_n = '0; hsize_n = '0; hpos_n = '0;
      dctl_n  = '0; dflg_n = '0; sctl_n  = '0; sdet_n = '0;
    end else begin
      if (reg_we.vsz)  vsize_n = data[3:0];
      if (reg_we.vps)  vpos_n  = data[POS_W-1:0];
      if (reg_we.hsz)  hsize_n = data[3:0];
      if (reg_we.hps)  hpos_n  = data[POS_W-1:0];
      if (reg_we.dctl) dctl_n  = data[3:1];
      if (reg_we.dflg) dflg_n  = data[5:0];
      if (reg_we.sctl) sctl_n  = data[3:0];
      if (reg_we.sdet) sdet_n  = data[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsize <= '0; vpos <= '0; hsize <= '0; hpos <= '0;
      disp_ctrl <= '0; disp_flags <= '0; sync_ctrl <= '0; sync_detect <= '0;
    end else begin
      vsize <= vsize_n; vpos <= vpos_n; hsize <= hsize_n; hpos <= hpos_n;
      disp_ctrl <= dctl_n; disp_flags <= dflg_n;
      sync_ctrl <= sctl_n; sync_detect <= sdet_n;
    end
  end
endmodule

// File: rtl/osd_vram_ptr.sv
module osd_vram_ptr #(
  parameter int LINES  = 10,
  parameter int COLS   = 24,
  parameter int CODE_W = 6,
  parameter int LINE_W = $clog2(LINES),
  parameter int COL_W  = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_line,
  input  logic              set_col,
  input  logic              char_wr,
  input  logic              clr_all,
  input  logic [7:0]        data,
  output logic              mem_we,
  output logic [LINE_W-1:0] mem_line,
  output logic [COL_W-1:0]  mem_col,
  output logic [CODE_W-1:0] mem_code,
  output logic              mem_attr,
  output logic [LINE_W-1:0] ptr_line,
  output logic [COL_W-1:0]  ptr_col
);
  logic [LINE_W-1:0] line_n, mline_n;
  logic [COL_W-1:0]  col_n, mcol_n;
  logic [CODE_W-1:0] code_n;
  logic              attr_n, we_n;

  always_comb begin
    line_n  = ptr_line;
    col_n   = ptr_col;
    mline_n = mem_line;
    mcol_n  = mem_col;
    code_n  = mem_code;
    attr_n  = mem_attr;
    we_n    = 1'b0;
    if (clr_all) begin
      line_n = '0; col_n = '0; mline_n = '0; mcol_n = '0;
      code_n = '0; attr_n = 1'b0;
    end else if (char_wr) begin
      we_n    = 1'b1;
      mline_n = ptr_line;
      mcol_n  = ptr_col;
      code_n  = data[CODE_W-1:0];
      attr_n  = data[7];
      if (ptr_col == COL_W'(COLS-1)) begin
        col_n  = '0;
        line_n = (ptr_line == LINE_W'(LINES-1)) ? '0 : ptr_line + 1'b1;
      end else begin
        col_n = ptr_col + 1'b1;
      end
    end else if (set_line) begin
      if (int'(data[3:0]) < LINES) line_n = LINE_W'(data[3:0]);
    end else if (set_col) begin
      if (int'(data[4:0]) < COLS) col_n = COL_W'(data[4:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_line <= '0; ptr_col <= '0; mem_we <= 1'b0;
      mem_line <= '0; mem_col <= '0; mem_code <= '0; mem_attr <= 1'b0;
    end else begin
      ptr_line <= line_n; ptr_col <= col_n; mem_we <= we_n;
      mem_line <= mline_n; mem_col <= mcol_n;
      mem_code <= code_n; mem_attr <= attr_n;
    end
  end
endmodule

// File: rtl/osd_serial_cmd.sv
module osd_serial_cmd
  import osd_cmd_pkg::*;
#(
  parameter int LINES       = 10,
  parameter int COLS        = 24,
  parameter int CODE_W      = 6,
  parameter int POS_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int LINE_W      = $clog2(LINES),
  parameter int COL_W       = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_cs_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              mem_we,
  output logic [LINE_W-1:0] mem_line,
  output logic [COL_W-1:0]  mem_col,
  output logic [CODE_W-1:0] mem_code,
  output logic              mem_attr,
  output logic [3:0]        vsize,
  output logic [POS_W-1:0]  vpos,
  output logic [3:0]        hsize,
  output logic [POS_W-1:0]  hpos,
  output logic [2:0]        disp_ctrl,
  output logic [5:0]        disp_flags,
  output logic [3:0]        sync_ctrl,
  output logic [3:0]        sync_detect,
  output logic              soft_rst_o
);
  logic              word_vld, cs_rise;
  logic [7:0]        word_q;
  osd_reg_we_t       reg_we;
  logic              clr_all, set_line, set_col, char_wr;
  logic [LINE_W-1:0] ptr_line;
  logic [COL_W-1:0]  ptr_col;

  osd_ser_rx #(.SYNC_STAGES(SYNC_STAGES), .WORD_W(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .word_vld(word_vld), .word_q(word_q), .cs_rise(cs_rise)
  );

  osd_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_d(word_q),
    .cs_rise(cs_rise), .reg_we(reg_we), .clr_all(clr_all),
    .set_line(set_line), .set_col(set_col), .char_wr(char_wr),
    .soft_rst(soft_rst_o)
  );

  osd_reg_file #(.POS_W(POS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .clr_all(clr_all),
    .data(word_q), .vsize(vsize), .vpos(vpos), .hsize(hsize), .hpos(hpos),
    .disp_ctrl(disp_ctrl), .disp_flags(disp_flags),
    .sync_ctrl(sync_ctrl), .sync_detect(sync_detect)
  );

  osd_vram_ptr #(.LINES(LINES), .COLS(COLS), .CODE_W(CODE_W),
                 .LINE_W(LINE_W), .COL_W(COL_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .set_line(set_line), .set_col(set_col),
    .char_wr(char_wr), .clr_all(clr_all), .data(word_q),
    .mem_we(mem_we), .mem_line(mem_line), .mem_col(mem_col),
    .mem_code(mem_code), .mem_attr(mem_attr),
    .ptr_line(ptr_line), .ptr_col(ptr_col)
  );
endmodule

// File: rtl/osd_serial_cmd_chk.sv
module osd_serial_cmd_chk #(
  parameter int LINES  = 10,
  parameter int COLS   = 24,
  parameter int LINE_W = $clog2(LINES),
  parameter int COL_W  = $clog2(COLS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_cs_n,
  input logic              mem_we,
  input logic [LINE_W-1:0] mem_line,
  input logic [COL_W-1:0]  mem_col,
  input logic [LINE_W-1:0] ptr_line,
  input logic [COL_W-1:0]  ptr_col,
  input logic [5:0]        disp_flags,
  input logic              soft_rst_o
);
  a_r6_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  a_r6_we_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(mem_line) < LINES && int'(mem_col) < COLS));

  // R6: pointer already sits one step past the reported write address
  a_r6_ptr_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(ptr_col) == ((int'(mem_col) == COLS-1) ? 0 : int'(mem_col) + 1)));

  a_r4_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_line) < LINES);

  a_r10_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (!mem_we && disp_flags == 6'd0));

  a_r10_release_on_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst_o) |-> ser_cs_n);
endmodule

bind osd_serial_cmd osd_serial_cmd_chk #(.LINES(LINES), .COLS(COLS),
  .LINE_W(LINE_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .mem_we(mem_we),
  .mem_line(mem_line), .mem_col(mem_col), .ptr_line(ptr_line),
  .ptr_col(ptr_col), .disp_flags(disp_flags), .soft_rst_o(soft_rst_o)
);

// File: tb/osd_serial_cmd_tb.sv
`timescale 1ns/1ps
module osd_serial_cmd_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_cs_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
  logic       mem_we, mem_attr, soft_rst_o;
  logic [3:0] mem_line, vsize, hsize, sync_ctrl, sync_detect;
  logic [4:0] mem_col;
  logic [5:0] mem_code, vpos, hpos, disp_flags;
  logic [2:0] disp_ctrl;

  int checks = 0, errors = 0, we_cnt = 0;
  int lg_line[32], lg_col[32], lg_code[32], lg_attr[32];

  always #2 clk = ~clk;

  osd_serial_cmd u_dut (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .mem_we(mem_we), .mem_line(mem_line),
    .mem_col(mem_col), .mem_code(mem_code), .mem_attr(mem_attr),
    .vsize(vsize), .vpos(vpos), .hsize(hsize), .hpos(hpos),
    .disp_ctrl(disp_ctrl), .disp_flags(disp_flags), .sync_ctrl(sync_ctrl),
    .sync_detect(sync_detect), .soft_rst_o(soft_rst_o)
  );

  always @(negedge clk) begin
    if (rst_n && mem_we && we_cnt < 32) begin
      lg_line[we_cnt] = int'(mem_line);
      lg_col[we_cnt]  = int'(mem_col);
      lg_code[we_cnt] = int'(mem_code);
      lg_attr[we_cnt] = int'(mem_attr);
      we_cnt++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      ser_dat = b[i];
      repeat (3) @(posedge clk);
      ser_clk = 1'b1;
      repeat (4) @(posedge clk);
      ser_clk = 1'b0;
      repeat (3) @(posedge clk);
    end
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic sel;
    ser_cs_n = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  task automatic desel;
    ser_cs_n = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_entry(input string tag, input int k,
                             input int l, input int c, input int cd, input int a);
    check({tag, " line"}, lg_line[k], l);
    check({tag, " col"},  lg_col[k], c);
    check({tag, " code"}, lg_code[k], cd);
    check({tag, " attr"}, lg_attr[k], a);
  endtask

  task automatic t_reset;
    check("R11 vsize", vsize, 0);   check("R11 vpos", vpos, 0);
    check("R11 hsize", hsize, 0);   check("R11 hpos", hpos, 0);
    check("R11 disp_ctrl", disp_ctrl, 0); check("R11 disp_flags", disp_flags, 0);
    check("R11 sync_ctrl", sync_ctrl, 0); check("R11 sync_detect", sync_detect, 0);
    check("R11 mem_we", mem_we, 0); check("R11 soft_rst_o", soft_rst_o, 0);
    check("R11 mem_line", mem_line, 0); check("R11 mem_code", mem_code, 0);
  endtask

  task automatic t_position;
    sel();
    send(8'hA9); check("R8 vsize", vsize, 9);
    send(8'h2A); check("R8 vpos", vpos, 'h2A);
    send(8'h15); check("R3 vpos repeat", vpos, 'h15);
    send(8'hB6); check("R8 hsize", hsize, 6);
    send(8'h3F); check("R8 hpos", hpos, 'h3F);
    check("R3 vpos kept", vpos, 'h15);
    desel();
  endtask

  task automatic t_control;
    sel();
    send(8'hCE); check("R9 disp_ctrl", disp_ctrl, 7);
    send(8'h21); check("R9 disp_flags", disp_flags, 'h21);
    send(8'hDA); check("R9 sync_ctrl", sync_ctrl, 'hA);
    send(8'h09); check("R9 sync_detect", sync_detect, 9);
    send(8'hE5); check("R2 invalid code sync_ctrl", sync_ctrl, 'hA);
    send(8'h05); check("R2 target kept after invalid", sync_detect, 5);
    check("R2 disp_flags untouched", disp_flags, 'h21);
    desel();
  endtask

  task automatic t_partial;
    sel();
    send_bits(8'hF0, 4);
    desel();
    sel();
    send(8'hA6); check("R1 vsize after partial", vsize, 6);
    send(8'h11); check("R1 vpos after partial", vpos, 'h11);
    desel();
  endtask

  task automatic t_char_lock;
    sel();
    send(8'h83); send(8'h05); send(8'h90);
    send(8'h8A); send(8'hBF);
    desel();
    check("R5 write count", we_cnt, 2);
    check_entry("R5 first", 0, 3, 5, 'h0A, 1);
    check_entry("R5 bit7 word", 1, 3, 6, 'h3F, 1);
    check("R5 hsize unchanged", hsize, 6);
  endtask

  task automatic t_wrap;
    sel();
    send(8'h89); send(8'h16); send(8'h90);
    send(8'h01); send(8'h02); send(8'h03);
    desel();
    sel();
    send(8'h84); send(8'h17); send(8'h90);
    send(8'h11); send(8'h12);
    desel();
    check("R6 write count", we_cnt, 7);
    check_entry("R6 col 22", 2, 9, 22, 1, 0);
    check_entry("R6 col 23", 3, 9, 23, 2, 0);
    check_entry("R6 last line wrap", 4, 0, 0, 3, 0);
    check_entry("R6 col end", 5, 4, 23, 'h11, 0);
    check_entry("R6 line advance", 6, 5, 0, 'h12, 0);
  endtask

  task automatic t_range;
    sel();
    send(8'h82); send(8'h03); send(8'h8C); send(8'h18);
    send(8'h90); send(8'h21);
    desel();
    check("R4 write count", we_cnt, 8);
    check_entry("R4 out of range ignored", 7, 2, 3, 'h21, 0);
  endtask

  task automatic t_cs_unlock;
    sel();
    send(8'h90); send(8'h22);
    desel();
    sel();
    send(8'h07);
    check("R7 no write after release", we_cnt, 9);
    send(8'h90); send(8'h23);
    desel();
    check("R7 write count", we_cnt, 10);
    check_entry("R7 pre-release", 8, 2, 4, 'h22, 0);
    check_entry("R7 column from data byte", 9, 2, 7, 'h23, 0);
  endtask

  task automatic t_soft_reset;
    sel();
    send(8'hC1);
    check("R10 soft_rst_o set", soft_rst_o, 1);
    check("R10 vsize clear", vsize, 0); check("R10 vpos clear", vpos, 0);
    check("R10 hpos clear", hpos, 0); check("R10 disp_flags clear", disp_flags, 0);
    check("R10 sync_ctrl clear", sync_ctrl, 0); check("R10 sync_detect clear", sync_detect, 0);
    check("R10 disp_ctrl clear", disp_ctrl, 0);
    send(8'hA3); check("R10 ignored while held", vsize, 0);
    desel();
    check("R10 released", soft_rst_o, 0);
    sel();
    send(8'h90); send(8'h05);
    desel();
    check("R10 write count", we_cnt, 11);
    check_entry("R10 pointer cleared", 10, 0, 0, 5, 0);
    sel();
    send(8'hA3); check("R10 writes resume", vsize, 3);
    desel();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_position();
    t_control();
    t_partial();
    t_char_lock();
    t_wrap();
    t_range();
    t_cs_unlock();
    t_soft_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule